// File: doc/BRIEF.md
# Multi-Line Transmit DMA Controller

This block moves outgoing bytes for a group of serial lines (16 by default) from memory to each line's transmitter. Every line has its own channel: a buffer address, a remaining byte count, a start flag, a transmitter enable and a stop request. Software picks a line by writing a line number into a selection register, and then reads or writes that line's channel registers through the same small register port.

One memory read port is shared by all lines. A round-robin arbiter grants one line at a time among those that can make progress. The controller issues one byte read, waits for the memory acknowledge, and then hands the byte to the granted line's transmitter with a one-cycle strobe. The address register counts up and the count register counts down as bytes go out. After a stop request or a failed read, software can therefore see how far the transfer got.

When a channel finishes, is stopped, or hits a read error, an entry is placed in a first-in first-out event queue. The entry holds the line number and an error flag. Software reads the event register until its valid flag is clear, and each read of a valid entry removes it.

Top module: `dmatx_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `mem_req` and `tx_valid` are low, the event register (offset 1) reads 0, and every line reads as idle with its start flag (bit 7 of offset 4) clear.
- R2: Offset 0 bits [3:0] select the line. Offsets 2 (count), 3 (address bits 15:0) and 4 (bits 5:0 carrying address bits 21:16) read and write the selected line only. Each line keeps its own values.
- R3: Writing 1 to bit 7 of offset 4 starts the line. The line then fetches `count` bytes from consecutive addresses. Each byte appears on `tx_data`, with its `tx_valid` bit high for one cycle, in the cycle after its read is acknowledged. The address rises by 1 and the count falls by 1 per byte. Bit 7 reads 1 while the line is active and clears when it completes.
- R4: A start write is ignored while the line is active, or while an event for that line is still queued. Writes to the count and address registers of an active line are ignored.
- R5: A line is never fetched for unless its transmit enable (offset 5 bit 0) is set and its `tx_ready` input is high.
- R6: Eligible lines are granted in round-robin order starting after the line granted last. The search begins at line 0 after reset. At most one `tx_valid` bit is high at a time.
- R7: Setting the stop bit (offset 5 bit 1) on an active line ends it at its next grant, without a fetch. It then queues an event with the error flag clear, and the address and count show the progress made.
- R8: A read acknowledged with `mem_err` sends no byte and ends the line. It queues an event with the error flag set, and it leaves the address at the failing byte.
- R9: The event register (offset 1) reads bit 15 = valid, bit 14 = error and bits [3:0] = line. Entries come out oldest first. A read of offset 1 while valid removes the entry, and the register reads 0 when the queue is empty.
- R10: Starting a line whose count is 0 completes it at its next grant with an error-free event and no memory read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the event queue at offset 1) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from offset and state |
| mem_req | output | 1 | Byte read request, held until acknowledged |
| mem_addr | output | 22 | Byte read address |
| mem_ack | input | 1 | Read acknowledge |
| mem_err | input | 1 | Read failed (no memory), valid with `mem_ack` |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| tx_ready | input | 16 | Per-line transmitter can take a byte |
| tx_valid | output | 16 | Per-line one-cycle byte strobe |
| tx_data | output | 8 | Byte for the strobed line |

## Verification
A register write is visible on a read in the next cycle. A start makes `mem_req` rise one clock later if the line wins the grant. The byte strobe follows the acknowledging edge by one clock, and the completion event can be read in the cycle after the final acknowledge, stop grant or zero-count grant. The bench keeps a behavioural model that it updates on the same rising edge as the design. It compares `mem_req`, `mem_addr`, `tx_valid` and `tx_data` on every falling edge, so each result is checked in the exact cycle it is due. Register reads are compared one time step after the read is driven, before the edge that would pop the queue.

// File: rtl/dmatx_pkg.sv
// Shared definitions for the transmit DMA controller: register offsets,
// bit positions and the fetch state type. Assumes a 16-bit register port.
package dmatx_pkg;
    localparam int REG_W = 16;

    localparam logic [2:0] RA_CTRL     = 3'd0;
    localparam logic [2:0] RA_EVENT    = 3'd1;
    localparam logic [2:0] RA_COUNT    = 3'd2;
    localparam logic [2:0] RA_ADDR_LO  = 3'd3;
    localparam logic [2:0] RA_ADDR_HI  = 3'd4;
    localparam logic [2:0] RA_LINE_CTL = 3'd5;

    localparam int EV_VALID_BIT = 15;
    localparam int EV_ERR_BIT   = 14;
    localparam int GO_BIT       = 7;
    localparam int TXEN_BIT     = 0;
    localparam int STOP_BIT     = 1;

    typedef enum logic {ST_IDLE, ST_WAIT} xfer_state_t;
endpackage

// File: rtl/dmatx_chan_bank.sv
// Per-line channel state: address, count, active, enable, stop and
// event-pending flags. Host writes apply to the selected line and only
// while that line is idle. The DMA side advances or finishes one line per cycle.
// Assumes 16 < ADDR_W <= 23 so the extended bits fit below the start bit.
module dmatx_chan_bank import dmatx_pkg::*; #(
    parameter int NLINES = 16,
    parameter int ADDR_W = 22,
    parameter int CNT_W  = 16,
    localparam int LINE_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] sel,
    input  logic              wr_cnt,
    input  logic              wr_alo,
    input  logic              wr_ahi,
    input  logic              wr_lctl,
    input  logic [REG_W-1:0]  wdata,
    input  logic              adv,
    input  logic [LINE_W-1:0] adv_line,
    input  logic              fin,
    input  logic [LINE_W-1:0] fin_line,
    input  logic              clr_pend,
    input  logic [LINE_W-1:0] clr_line,
    output logic [ADDR_W-1:0] addr_o [NLINES],
    output logic [CNT_W-1:0]  cnt_o  [NLINES],
    output logic [NLINES-1:0] act_o,
    output logic [NLINES-1:0] txen_o,
    output logic [NLINES-1:0] stop_o,
    output logic [NLINES-1:0] pend_o
);
    localparam int XW = ADDR_W - 16;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic [ADDR_W-1:0] addr_q;
        logic [CNT_W-1:0]  cnt_q;
        logic              act_q, txen_q, stop_q, pend_q;
        logic              hit, adv_me, fin_me;

        assign hit    = (sel == LINE_W'(i));
        assign adv_me = adv && (adv_line == LINE_W'(i));
        assign fin_me = fin && (fin_line == LINE_W'(i));

        // Address and count: advance per sent byte, host load while idle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_q <= '0;
                cnt_q  <= '0;
            end else if (adv_me) begin
                addr_q <= addr_q + 1'b1;
                cnt_q  <= cnt_q - 1'b1;
            end else if (hit && !act_q) begin
                if (wr_cnt) cnt_q <= wdata[CNT_W-1:0];
                if (wr_alo) addr_q[15:0] <= wdata;
                if (wr_ahi) addr_q[ADDR_W-1:16] <= wdata[XW-1:0];
            end
        end

        // Active flag: set by an accepted start, cleared at completion.
        always_ff @(posedge clk) begin
            if (!rst_n)
                act_q <= 1'b0;
            else if (fin_me)
                act_q <= 1'b0;
            else if (wr_ahi && hit && wdata[GO_BIT] && !act_q && !pend_q)
                act_q <= 1'b1;
        end

        // Pending flag: one queued event per line at most.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q <= 1'b0;
            else if (fin_me)
                pend_q <= 1'b1;
            else if (clr_pend && clr_line == LINE_W'(i))
                pend_q <= 1'b0;
        end

        // Line control: transmit enable and stop request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                txen_q <= 1'b0;
                stop_q <= 1'b0;
            end else if (wr_lctl && hit) begin
                txen_q <= wdata[TXEN_BIT];
                stop_q <= wdata[STOP_BIT];
            end
        end

        assign addr_o[i] = addr_q;
        assign cnt_o[i]  = cnt_q;
        assign act_o[i]  = act_q;
        assign txen_o[i] = txen_q;
        assign stop_o[i] = stop_q;
        assign pend_o[i] = pend_q;

        // R3
        fin_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fin_me |-> act_q);
        // R4
        pend_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pend_q |-> !act_q);
    end
endmodule

// File: rtl/dmatx_rr_arb.sv
// Round-robin arbiter: grants the first requester after the last winner.
// The pointer moves only when the grant is taken. Assumes N >= 2.
module dmatx_rr_arb #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] last_q;

    // Search requesters in order starting after the last winner.
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = 1; k <= N; k++) begin
            if (!gnt_valid && req[(int'(last_q) + k) % N]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IW'((int'(last_q) + k) % N);
            end
        end
    end

    // Remember the winner; after reset the search starts at index 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= IW'(N - 1);
        else if (take && gnt_valid)
            last_q <= gnt_idx;
    end
endmodule

// File: rtl/dmatx_evq.sv
// Completion event FIFO. The oldest entry is shown on head.
// Assumes DEPTH is a power of two and that the producer never overfills it.
module dmatx_evq #(
    parameter int DEPTH = 16,
    parameter int W     = 5,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [PW:0]   cnt_q;

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem_q[wr_q] <= din;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= wr_q + 1'b1;
            if (pop)  rd_q <= rd_q + 1'b1;
            cnt_q <= cnt_q + (PW+1)'(push) - (PW+1)'(pop);
        end
    end

    assign head  = mem_q[rd_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == (PW+1)'(DEPTH));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |-> !full);
    // R9
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/dmatx_ctrl.sv
// Transmit DMA controller top. It decodes the register port, arbitrates one
// byte fetch at a time over the shared memory port, strobes the fetched
// byte to the line's transmitter, and queues completion events.
// Assumes a single outstanding memory read and a memory that eventually acks.
module dmatx_ctrl import dmatx_pkg::*; #(
    parameter int NLINES = 16,
    parameter int ADDR_W = 22,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [7:0]        mem_rdata,
    input  logic [NLINES-1:0] tx_ready,
    output logic [NLINES-1:0] tx_valid,
    output logic [7:0]        tx_data
);
    localparam int LINE_W = $clog2(NLINES);
    localparam int EV_W   = LINE_W + 1;

    logic [LINE_W-1:0] sel_q;
    logic [ADDR_W-1:0] ch_addr [NLINES];
    logic [CNT_W-1:0]  ch_cnt  [NLINES];
    logic [NLINES-1:0] ch_act, ch_txen, ch_stop, ch_pend, eligible;

    xfer_state_t       state_q;
    logic [LINE_W-1:0] line_q;
    logic              req_q;
    logic [ADDR_W-1:0] maddr_q;
    logic [NLINES-1:0] txv_q;
    logic [7:0]        txd_q;

    logic              gnt_valid, take, quick, issue, acked;
    logic [LINE_W-1:0] gnt_idx;
    logic              fin, fin_err, adv, pop;
    logic [LINE_W-1:0] fin_line;
    logic [EV_W-1:0]   ev_head;
    logic              ev_empty, ev_full;

    logic wr_cnt, wr_alo, wr_ahi, wr_lctl;
    assign wr_cnt  = reg_wr && reg_addr == RA_COUNT;
    assign wr_alo  = reg_wr && reg_addr == RA_ADDR_LO;
    assign wr_ahi  = reg_wr && reg_addr == RA_ADDR_HI;
    assign wr_lctl = reg_wr && reg_addr == RA_LINE_CTL;

    // Line can progress: stop or empty count needs no fetch, else needs a ready transmitter.
    always_comb begin
        for (int i = 0; i < NLINES; i++)
            eligible[i] = ch_act[i] && (ch_stop[i] || ch_cnt[i] == '0 ||
                                        (ch_txen[i] && tx_ready[i]));
    end

    assign take    = (state_q == ST_IDLE);
    assign quick   = ch_stop[gnt_idx] || ch_cnt[gnt_idx] == '0;
    assign issue   = take && gnt_valid && !quick;
    assign acked   = (state_q == ST_WAIT) && mem_ack;
    assign adv     = acked && !mem_err;
    assign fin_err = acked && mem_err;
    assign fin     = (take && gnt_valid && quick) ||
                     (acked && (mem_err || ch_cnt[line_q] == CNT_W'(1)));
    assign fin_line = take ? gnt_idx : line_q;
    assign pop     = reg_rd && reg_addr == RA_EVENT && !ev_empty;

    dmatx_rr_arb #(.N(NLINES)) i_arb (
        .clk(clk), .rst_n(rst_n), .req(eligible), .take(take),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
    );

    dmatx_chan_bank #(.NLINES(NLINES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_bank (
        .clk(clk), .rst_n(rst_n), .sel(sel_q),
        .wr_cnt(wr_cnt), .wr_alo(wr_alo), .wr_ahi(wr_ahi), .wr_lctl(wr_lctl),
        .wdata(reg_wdata), .adv(adv), .adv_line(line_q),
        .fin(fin), .fin_line(fin_line),
        .clr_pend(pop), .clr_line(ev_head[LINE_W-1:0]),
        .addr_o(ch_addr), .cnt_o(ch_cnt), .act_o(ch_act),
        .txen_o(ch_txen), .stop_o(ch_stop), .pend_o(ch_pend)
    );

    dmatx_evq #(.DEPTH(NLINES), .W(EV_W)) i_evq (
        .clk(clk), .rst_n(rst_n), .push(fin), .din({fin_err, fin_line}),
        .pop(pop), .head(ev_head), .empty(ev_empty), .full(ev_full)
    );

    // Line select register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (reg_wr && reg_addr == RA_CTRL)
            sel_q <= reg_wdata[LINE_W-1:0];
    end

    // Fetch sequencer: issue one read, then strobe the byte on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
            req_q   <= 1'b0;
            maddr_q <= '0;
            txv_q   <= '0;
            txd_q   <= '0;
        end else begin
            txv_q <= '0;
            if (issue) begin
                state_q <= ST_WAIT;
                line_q  <= gnt_idx;
                req_q   <= 1'b1;
                maddr_q <= ch_addr[gnt_idx];
            end else if (acked) begin
                state_q <= ST_IDLE;
                req_q   <= 1'b0;
                if (!mem_err) begin
                    txv_q[line_q] <= 1'b1;
                    txd_q         <= mem_rdata;
                end
            end
        end
    end

    // Register read multiplexer for the selected line.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL:     reg_rdata = 16'(sel_q);
            RA_EVENT:    if (!ev_empty) begin
                             reg_rdata = 16'(ev_head[LINE_W-1:0]);
                             reg_rdata[EV_VALID_BIT] = 1'b1;
                             reg_rdata[EV_ERR_BIT]   = ev_head[EV_W-1];
                         end
            RA_COUNT:    reg_rdata = 16'(ch_cnt[sel_q]);
            RA_ADDR_LO:  reg_rdata = ch_addr[sel_q][15:0];
            RA_ADDR_HI:  begin
                             reg_rdata = 16'(ch_addr[sel_q][ADDR_W-1:16]);
                             reg_rdata[GO_BIT] = ch_act[sel_q];
                         end
            RA_LINE_CTL: begin
                             reg_rdata[TXEN_BIT] = ch_txen[sel_q];
                             reg_rdata[STOP_BIT] = ch_stop[sel_q];
                         end
            default:     reg_rdata = '0;
        endcase
    end

    assign mem_req  = req_q;
    assign mem_addr = maddr_q;
    assign tx_valid = txv_q;
    assign tx_data  = txd_q;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
    // R5
    issue_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> ch_txen[gnt_idx] && tx_ready[gnt_idx]);
    // R6
    tx_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_valid));
    // R8
    err_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && mem_err |=> tx_valid == '0);
endmodule

// File: tb/test_dmatx_ctrl.sv
`timescale 1ns/1ps
module test_dmatx_ctrl;
    localparam int NL = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        mem_req;
    logic [21:0] mem_addr;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic [NL-1:0] tx_ready = '1;
    logic [NL-1:0] tx_valid;
    logic [7:0]  tx_data;

    dmatx_ctrl i_dmatx_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_err(mem_err), .mem_rdata(mem_rdata), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0, lat = 0, wcnt = 0;
    bit finished = 0;

    // Behavioural reference model state.
    int m_addr [NL];
    int m_cnt  [NL];
    bit [NL-1:0] m_act, m_txen, m_stop, m_pend;
    int m_sel, m_rr, m_line, m_txv, m_txd, m_maddr;
    bit m_wait, m_req;
    logic [4:0] mq [$];

    function automatic logic [7:0] mem_fn(input logic [21:0] a);
        return 8'((a * 5 + 3) ^ (a >> 8));
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Memory responder: acks after lat waiting cycles, fails in the top 64 KiB page.
    always @(negedge clk) begin
        if (mem_req) begin
            if (wcnt >= lat) begin
                mem_ack = 1'b1;
                mem_rdata = mem_fn(mem_addr);
                mem_err = (mem_addr[21:16] == 6'h3F);
                wcnt = 0;
            end else begin
                mem_ack = 1'b0;
                wcnt++;
            end
        end else begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
            wcnt = 0;
        end
    end

    // Reference model update on the same edge as the design.
    always @(posedge clk) begin
        bit [NL-1:0] o_act, o_pend, o_stop, o_txen;
        int found;
        if (!rst_n) begin
            for (int i = 0; i < NL; i++) begin m_addr[i] = 0; m_cnt[i] = 0; end
            m_act = '0; m_txen = '0; m_stop = '0; m_pend = '0;
            m_sel = 0; m_rr = NL - 1; m_wait = 0; m_req = 0; m_txv = -1;
            m_txd = 0; m_maddr = 0; m_line = 0;
            mq.delete();
        end else begin
            o_act = m_act; o_pend = m_pend; o_stop = m_stop; o_txen = m_txen;
            m_txv = -1;
            if (reg_rd && reg_addr == 3'd1 && mq.size() > 0) begin
                m_pend[mq[0][3:0]] = 1'b0;
                void'(mq.pop_front());
            end
            if (!m_wait) begin
                found = -1;
                for (int k = 1; k <= NL; k++) begin
                    int i;
                    i = (m_rr + k) % NL;
                    if (found < 0 && o_act[i] &&
                        (o_stop[i] || m_cnt[i] == 0 || (o_txen[i] && tx_ready[i])))
                        found = i;
                end
                if (found >= 0) begin
                    m_rr = found;
                    if (o_stop[found] || m_cnt[found] == 0) begin
                        m_act[found] = 0; m_pend[found] = 1;
                        mq.push_back({1'b0, 4'(found)});
                    end else begin
                        m_wait = 1; m_req = 1; m_line = found;
                        m_maddr = m_addr[found];
                    end
                end
            end else if (mem_ack) begin
                m_wait = 0; m_req = 0;
                if (mem_err) begin
                    m_act[m_line] = 0; m_pend[m_line] = 1;
                    mq.push_back({1'b1, 4'(m_line)});
                end else begin
                    m_txv = m_line; m_txd = mem_rdata;
                    m_addr[m_line] = (m_addr[m_line] + 1) & 22'h3FFFFF;
                    m_cnt[m_line] = m_cnt[m_line] - 1;
                    if (m_cnt[m_line] == 0) begin
                        m_act[m_line] = 0; m_pend[m_line] = 1;
                        mq.push_back({1'b0, 4'(m_line)});
                    end
                end
            end
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_sel = int'(reg_wdata[3:0]);
                    3'd2: if (!o_act[m_sel]) m_cnt[m_sel] = int'(reg_wdata);
                    3'd3: if (!o_act[m_sel])
                              m_addr[m_sel] = (m_addr[m_sel] & 32'h3F0000) | int'(reg_wdata);
                    3'd4: begin
                        if (!o_act[m_sel])
                            m_addr[m_sel] = (m_addr[m_sel] & 32'hFFFF) | (int'(reg_wdata[5:0]) << 16);
                        if (reg_wdata[7] && !o_act[m_sel] && !o_pend[m_sel])
                            m_act[m_sel] = 1;
                    end
                    3'd5: begin m_txen[m_sel] = reg_wdata[0]; m_stop[m_sel] = reg_wdata[1]; end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [15:0] model_rd(input int a);
        case (a)
            0: return 16'(m_sel);
            1: return (mq.size() > 0) ? {1'b1, mq[0][4], 10'b0, mq[0][3:0]} : 16'h0;
            2: return 16'(m_cnt[m_sel]);
            3: return 16'(m_addr[m_sel]);
            4: return 16'(((m_addr[m_sel] >> 16) & 63) | (int'(m_act[m_sel]) << 7));
            5: return {14'b0, m_stop[m_sel], m_txen[m_sel]};
            default: return 16'h0;
        endcase
    endfunction

    // Per-cycle comparison of the memory and transmitter ports with the model.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NL-1:0] exp_v;
            bit ok;
            exp_v = (m_txv >= 0) ? (NL'(1) << m_txv) : '0;
            ok = (mem_req === m_req) && (!m_req || mem_addr === 22'(m_maddr)) &&
                 (tx_valid === exp_v) && (m_txv < 0 || tx_data === 8'(m_txd));
            chk(ok, "R3 R5 R6 R8 per-cycle req/addr/tx",
                {mem_req, tx_valid}, {m_req, exp_v});
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // Read a register and check it against the model and, if given, a fixed value.
    task automatic reg_check(input logic [2:0] a, input bit use_fix,
                             input logic [15:0] fix, input string tag,
                             output logic [15:0] got);
        logic [15:0] exp;
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1;
        exp = use_fix ? fix : model_rd(int'(a));
        got = reg_rdata;
        chk(got === exp && (!use_fix || fix === model_rd(int'(a))), tag, got, exp);
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic prog(input int line, input int addr, input int cnt, input bit go);
        reg_write(3'd0, 16'(line));
        reg_write(3'd2, 16'(cnt));
        reg_write(3'd3, 16'(addr));
        reg_write(3'd4, 16'((addr >> 16) & 63) | (go ? 16'h0080 : 16'h0));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v, a0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(mem_req === 1'b0 && tx_valid === '0, "R1 outputs idle", {mem_req, tx_valid}, 0);
        reg_check(3'd1, 1, 16'h0000, "R1 event empty", v);
        reg_check(3'd4, 1, 16'h0000, "R1 line 0 idle", v);

        // enable all lines except 6
        for (int i = 0; i < NL; i++) begin
            reg_write(3'd0, 16'(i));
            reg_write(3'd5, (i == 6) ? 16'h0 : 16'h1);
        end

        // R2 per-line registers
        prog(2, 32'h0100, 3, 0);
        prog(3, 32'h0200, 5, 0);
        reg_write(3'd0, 16'd2);
        reg_check(3'd2, 1, 16'd3, "R2 line 2 count", v);
        reg_check(3'd3, 1, 16'h0100, "R2 line 2 address", v);
        reg_write(3'd0, 16'd3);
        reg_check(3'd2, 1, 16'd5, "R2 line 3 count", v);
        reg_check(3'd0, 1, 16'd3, "R2 select readback", v);

        // R3 basic transfer
        reg_write(3'd0, 16'd2);
        reg_write(3'd4, 16'h0080);
        reg_check(3'd4, 1, 16'h0080, "R3 go reads active", v);
        idle(20);
        reg_check(3'd3, 1, 16'h0103, "R3 address advanced by count", v);
        reg_check(3'd2, 1, 16'h0000, "R3 count drained", v);
        reg_check(3'd4, 1, 16'h0000, "R3 go self-cleared", v);
        reg_check(3'd1, 1, 16'h8002, "R9 event line 2", v);
        reg_check(3'd1, 1, 16'h0000, "R9 queue empty after pop", v);

        // R6 round robin with three lines and slower memory
        lat = 2;
        prog(1, 32'h1000, 4, 1);
        prog(5, 32'h2000, 4, 1);
        prog(9, 32'h3000, 4, 1);
        idle(80);
        for (int k = 0; k < 3; k++)
            reg_check(3'd1, 0, 16'h0, "R6 R9 event order", v);
        reg_check(3'd1, 1, 16'h0000, "R9 drained", v);

        // R4 writes while active are ignored
        lat = 3;
        prog(7, 32'h4000, 20, 1);
        idle(10);
        reg_write(3'd2, 16'd1);
        reg_write(3'd3, 16'h0000);
        reg_write(3'd4, 16'h0080);
        reg_check(3'd2, 0, 16'h0, "R4 count write ignored", v);
        chk(v != 16'd1, "R4 count not overwritten", v, 1);
        reg_check(3'd3, 0, 16'h0, "R4 address write ignored", v);
        chk(v != 16'h0000, "R4 address not overwritten", v, 16'h4000);

        // R7 stop mid-transfer
        reg_write(3'd5, 16'h0003);
        idle(30);
        reg_check(3'd1, 1, 16'h8007, "R7 stop event no error", v);
        reg_check(3'd3, 0, 16'h0, "R7 address shows progress", a0);
        reg_check(3'd2, 0, 16'h0, "R7 count shows remainder", v);
        chk(int'(a0) - 32'h4000 + int'(v) == 20, "R7 sent plus remaining", int'(a0) - 32'h4000 + int'(v), 20);
        reg_check(3'd4, 1, 16'h0000, "R7 go cleared", v);
        reg_write(3'd5, 16'h0001);

        // R8 read error
        lat = 0;
        prog(3, 32'h3F0010, 2, 1);
        idle(20);
        reg_check(3'd1, 1, 16'hC003, "R8 error event", v);
        reg_check(3'd3, 1, 16'h0010, "R8 address at failing byte", v);
        reg_check(3'd4, 1, 16'h003F, "R8 go cleared", v);

        // R5 gating by tx_ready and by transmit enable
        tx_ready[4] = 1'b0;
        prog(4, 32'h5000, 2, 1);
        prog(6, 32'h6000, 1, 1);
        idle(20);
        reg_check(3'd4, 1, 16'h0080, "R5 line 6 waits for enable", v);
        reg_write(3'd0, 16'd4);
        reg_check(3'd3, 1, 16'h5000, "R5 line 4 waits for ready", v);
        reg_check(3'd4, 1, 16'h0080, "R5 line 4 still active", v);
        tx_ready[4] = 1'b1;
        reg_write(3'd0, 16'd6);
        reg_write(3'd5, 16'h0001);
        idle(30);
        reg_check(3'd1, 0, 16'h0, "R5 R9 first released event", v);
        reg_check(3'd1, 0, 16'h0, "R5 R9 second released event", v);

        // R10 zero count
        prog(8, 32'h7000, 0, 1);
        idle(5);
        reg_check(3'd1, 1, 16'h8008, "R10 zero count event", v);
        reg_check(3'd4, 1, 16'h0000, "R10 go cleared", v);

        // R4 start blocked while an event is queued
        prog(10, 32'h7100, 1, 1);
        idle(15);
        prog(10, 32'h7200, 2, 1);
        idle(15);
        reg_check(3'd4, 1, 16'h0000, "R4 start ignored while event queued", v);
        reg_check(3'd2, 1, 16'd2, "R4 nothing fetched", v);
        reg_check(3'd1, 1, 16'h800A, "R9 queued event line 10", v);
        reg_check(3'd1, 1, 16'h0000, "R9 empty", v);
        reg_write(3'd4, 16'h0080);
        idle(15);
        reg_check(3'd1, 1, 16'h800A, "R4 restart after pop completes", v);
        reg_check(3'd3, 1, 16'h7202, "R3 second transfer address", v);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule